// File: doc/BRIEF.md
# Smart-card answer-to-reset transmitter

This block is the card-side sender of the answer-to-reset string. While the card's active-low reset line is held low, the host side of the chip loads an eight-byte answer-to-reset register through a simple write port. When the reset line is released and the asynchronous-mode enable strap is high, the block waits a fixed number of carrier cycles. It then sends the eight bytes, byte 0 first, as asynchronous character frames on an open-drain I/O line. All bit timing is derived from the carrier clock: one bit lasts a fixed count of carrier cycles, 372 by default.

The block never drives the I/O line high. It only requests a pull-low, and an external pull-up supplies the high level. Pulling reset low at any point stops a transmission at once and releases the line. The next release starts the whole string again from byte 0. With the strap low, a reset release produces no output at all, which suits synchronous-only use.

The controller has seven states:
- IDLE: held while in reset, or kept when the strap is low.
- DELAY: the wait after reset release.
- START: the start bit.
- DATA: the eight data bits.
- PARITY: the parity bit.
- GUARD: the released guard time.
- DONE: the string is complete.

The transitions are:
- IDLE to DELAY on the first clock after release when the strap is high.
- DELAY to START when the delay expires.
- START to DATA after one bit time.
- DATA to PARITY after the eighth data bit.
- PARITY to GUARD after one bit time.
- GUARD to START when more bytes remain.
- GUARD to DONE after the last byte.
- Any state to IDLE whenever reset goes low.

Top module: `atr_tx`

## Requirements
- R1: Every bit lasts exactly ETU_CYCLES (default 372) carrier cycles, and `io_pull_low` changes only at bit boundaries.
- R2: With the strap high, the first start bit begins at the START_DELAY-th (default 400) rising carrier edge after `rst_n` rises. Before that edge, `io_pull_low` is 0.
- R3: Each byte is framed as follows:
  - a start bit (`io_pull_low`=1);
  - eight data bits, least significant first, with `io_pull_low`=1 exactly when the data bit is 0;
  - an even-parity bit whose value is the XOR of the eight data bits, with `io_pull_low`=1 exactly when that value is 0;
  - a guard time of GUARD_ETUS (default 2) bit times with `io_pull_low`=0.
- R4: Bytes are sent in register order. The byte written at `wr_addr`=0 goes first and the byte at address NUM_BYTES-1 goes last.
- R5: `atr_done` rises on the clock edge that ends the guard time after the last byte. It then stays 1 with `io_pull_low`=0 until `rst_n` goes low.
- R6: When `rst_n` falls during a transmission, `io_pull_low` and `atr_done` drop to 0 at once, without waiting for a clock. The next release sends the whole string again from byte 0.
- R7: A write (`wr_en`=1 at a rising edge) stores `wr_data` at `wr_addr` only while `rst_n` is 0. Writes while `rst_n` is 1 leave the register unchanged.
- R8: If `async_en` is 0 when reset is released, nothing is sent. `io_pull_low` and `atr_done` stay 0.
- R9: While `rst_n` is 0, `io_pull_low` and `atr_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock; all bit timing counts its rising edges |
| rst_n | input | 1 | Card reset line, active low; its release starts the answer-to-reset |
| async_en | input | 1 | Strap: 1 enables the asynchronous answer-to-reset |
| wr_en | input | 1 | Register write strobe, honoured only while rst_n is 0 |
| wr_addr | input | 3 | Byte index of the write |
| wr_data | input | 8 | Byte value to store |
| io_pull_low | output | 1 | 1 asks the open-drain I/O pad to pull the line low |
| atr_done | output | 1 | 1 once the complete string and final guard time have been sent |

## Verification
The checker assumes that the enable strap is static for the whole time reset is high. It also assumes that reset is low at the first clock edge. The checks for a silent line with the strap off and for level changes only on bit-timer wrap points rest on these two assumptions. The bench changes `async_en` only while `rst_n` is low, and it starts with reset asserted. It drives reset and register writes on falling carrier edges, so that every transition lands cleanly between rising edges.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD,
        ST_DONE
    } atr_state_e;

endpackage

// File: rtl/atr_byte_store.sv
module atr_byte_store #(
    parameter int NUM_BYTES = 8,
    parameter int AW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data
);

    logic [7:0] bytes_q [NUM_BYTES];

    // Loading is only legal while the card is held in reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_en && !rst_n && wr_addr == AW'(i)) begin
                bytes_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = bytes_q[rd_idx];

endmodule

// File: rtl/atr_etu_timer.sv
module atr_etu_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          tick
);

    logic [CW-1:0] cnt_q;

    assign tick = !clear && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/atr_tx.sv
module atr_tx #(
    parameter int ETU_CYCLES  = 372,
    parameter int START_DELAY = 400,
    parameter int GUARD_ETUS  = 2,
    parameter int NUM_BYTES   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       async_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       io_pull_low,
    output logic       atr_done
);
    import atr_pkg::*;

    localparam int AW        = $clog2(NUM_BYTES);
    localparam int GUARD_CYC = GUARD_ETUS * ETU_CYCLES;
    localparam int LIM_A     = (GUARD_CYC > ETU_CYCLES) ? GUARD_CYC : ETU_CYCLES;
    localparam int LIM_MAX   = (LIM_A > START_DELAY) ? LIM_A : START_DELAY;
    localparam int CW        = $clog2(LIM_MAX + 1);

    atr_state_e     state, state_nxt;
    logic [2:0]     bit_idx;
    logic [AW-1:0]  byte_idx;
    logic [7:0]     cur_byte;
    logic [CW-1:0]  limit;
    logic           tick;
    logic           timer_clear;
    logic           last_byte;

    atr_byte_store #(
        .NUM_BYTES(NUM_BYTES),
        .AW       (AW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr[AW-1:0]),
        .wr_data (wr_data),
        .rd_idx  (byte_idx),
        .rd_data (cur_byte)
    );

    atr_etu_timer #(
        .CW(CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .limit (limit),
        .tick  (tick)
    );

    assign timer_clear = (state == ST_IDLE) || (state == ST_DONE);
    assign last_byte   = (byte_idx == AW'(NUM_BYTES - 1));

    // IDLE uses one edge, so DELAY is one cycle shorter than the full delay
    always_comb begin
        unique case (state)
            ST_DELAY: limit = CW'(START_DELAY - 1);
            ST_GUARD: limit = CW'(GUARD_CYC);
            default:  limit = CW'(ETU_CYCLES);
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (async_en) state_nxt = ST_DELAY;
            ST_DELAY:  if (tick) state_nxt = ST_START;
            ST_START:  if (tick) state_nxt = ST_DATA;
            ST_DATA:   if (tick && bit_idx == 3'd7) state_nxt = ST_PARITY;
            ST_PARITY: if (tick) state_nxt = ST_GUARD;
            ST_GUARD:  if (tick) state_nxt = last_byte ? ST_DONE : ST_START;
            ST_DONE:   state_nxt = ST_DONE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register; reset is asynchronous so an abort frees the line at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            byte_idx <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_DATA && tick) begin
                bit_idx <= bit_idx + 3'd1;
            end
            if (state == ST_GUARD && tick && !last_byte) begin
                byte_idx <= byte_idx + AW'(1);
            end
        end
    end

    always_comb begin
        io_pull_low = 1'b0;
        atr_done    = 1'b0;
        unique case (state)
            ST_START:  io_pull_low = 1'b1;
            ST_DATA:   io_pull_low = ~cur_byte[bit_idx];
            ST_PARITY: io_pull_low = ~(^cur_byte);
            ST_DONE:   atr_done    = 1'b1;
            default:   io_pull_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/atr_tx_chk.sv
module atr_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic async_en,
    input logic io_pull_low,
    input logic atr_done,
    input logic tick
);

    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            AST_RESET_QUIET: assert (!io_pull_low && !atr_done) else $error("line active in reset"); // R9
        end
    end

    AST_BIT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (io_pull_low != $past(io_pull_low)) |-> $past(tick)); // R1

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        atr_done |=> atr_done); // R5

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        atr_done |-> !io_pull_low); // R5

    AST_STRAP_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !async_en |-> (!io_pull_low && !atr_done)); // R8

endmodule

bind atr_tx atr_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .async_en    (async_en),
    .io_pull_low (io_pull_low),
    .atr_done    (atr_done),
    .tick        (tick)
);

// File: tb/atr_tx_tb.sv
`timescale 1ns/1ps
module atr_tx_tb;

    localparam int ETU   = 372;
    localparam int DLY   = 400;
    localparam int NB    = 8;
    localparam int SLOTS = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       async_en;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       io_pull_low;
    logic       atr_done;

    int n_chk  = 0;
    int n_fail = 0;
    int cur    = 0;
    bit ended  = 1'b0;
    logic [7:0] model [NB];

    always #5 clk = ~clk;

    atr_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_en    (async_en),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .io_pull_low (io_pull_low),
        .atr_done    (atr_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_low(input logic [7:0] b, input int s);
        if (s == 0)      return 1'b1;
        else if (s <= 8) return ~b[s-1];
        else if (s == 9) return ~(^b);
        else             return 1'b0;
    endfunction

    // Move to the falling edge after the t-th rising edge since release
    task automatic goto(input int t);
        repeat (t - cur) @(posedge clk);
        @(negedge clk);
        cur = t;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_addr = a[2:0];
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic release_rst();
        rst_n = 1'b1;
        cur   = 0;
    endtask

    task automatic check_full(input string tag);
        int base;
        goto(DLY - 1);
        check({"R2 line idle before start ", tag}, io_pull_low, 0);
        goto(DLY);
        check({"R2 start at delay edge ", tag}, io_pull_low, 1);
        for (int b = 0; b < NB; b++) begin
            for (int s = 0; s < SLOTS; s++) begin
                base = DLY + (b * SLOTS + s) * ETU;
                goto(base + ETU / 2);
                check($sformatf("R3 R4 byte %0d slot %0d mid %s", b, s, tag),
                      io_pull_low, exp_low(model[b], s));
                goto(base + ETU - 1);
                check($sformatf("R1 byte %0d slot %0d end %s", b, s, tag),
                      io_pull_low, exp_low(model[b], s));
            end
        end
        check({"R5 done low before final edge ", tag}, atr_done, 0);
        goto(DLY + NB * SLOTS * ETU);
        check({"R5 done raised ", tag}, atr_done, 1);
        check({"R5 line released when done ", tag}, io_pull_low, 0);
        goto(DLY + NB * SLOTS * ETU + 500);
        check({"R5 done held ", tag}, atr_done, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r        = $urandom(32'd2024);
        rst_n    = 1'b0;
        async_en = 1'b1;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        repeat (3) @(negedge clk);
        check("R9 reset line released", io_pull_low, 0);
        check("R9 reset done low", atr_done, 0);

        // Run A: directed all-zero and all-one bytes, then random bytes
        model[0] = 8'h00;
        model[1] = 8'hFF;
        for (int i = 2; i < NB; i++) model[i] = 8'($urandom);
        for (int i = 0; i < NB; i++) wr(i, model[i]);
        release_rst();
        check_full("run A R7 load");

        // Writes while reset is high must be dropped
        for (int i = 0; i < NB; i++) wr(i, ~model[i]);
        check("R7 done unaffected by ignored writes", atr_done, 1);
        check("R7 line unaffected by ignored writes", io_pull_low, 0);

        // Partial reload in reset, byte 2 bit 3 forced to 0 for the abort point
        rst_n = 1'b0;
        @(negedge clk);
        model[2] = 8'($urandom) & 8'hF7;
        model[5] = 8'($urandom);
        wr(2, model[2]);
        wr(5, model[5]);

        // Abort in the middle of byte 2, data bit 3 (slot 4)
        release_rst();
        goto(DLY + (2 * SLOTS + 4) * ETU + 100);
        check("R3 abort point pulls low", io_pull_low, 1);
        rst_n = 1'b0;
        #1;
        check("R6 abort releases line at once", io_pull_low, 0);
        check("R6 abort done low", atr_done, 0);
        repeat (20) @(negedge clk);

        // Run B: restarts from byte 0, ignored writes left no trace
        release_rst();
        check_full("run B R6 R7");

        // Strap off: nothing is sent
        rst_n = 1'b0;
        @(negedge clk);
        async_en = 1'b0;
        @(negedge clk);
        release_rst();
        for (int k = 1; k <= 8; k++) begin
            goto(k * 300);
            check($sformatf("R8 strap off line idle t=%0d", k * 300), io_pull_low, 0);
            check($sformatf("R8 strap off done low t=%0d", k * 300), atr_done, 0);
        end

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule